// File: doc/BRIEF.md
# Fixed-Latency Writeback Arbiter for Three Execution Lanes

This block decides, each cycle, which of a few ready micro-ops go to which execution lane. There are three lanes, carrying the port numbers 0, 1 and 5. Every micro-op carries a latency class that fixes how many cycles it needs before its result is written back. Each lane has a single writeback path. The arbiter therefore keeps a reservation map per lane that records the future cycles in which a result is already due. A micro-op is dispatched only when the lane's writeback cycle for that micro-op is still free. As a result, no lane ever produces two results in the same cycle.

The block holds no micro-op state of its own. The issuing stage presents candidates in numbered input slots, where slot 0 is the oldest. A candidate whose grant stays low must be presented again in the next cycle. A granted micro-op reappears on its lane's writeback output after exactly its latency, carrying its tag. No arithmetic is done; the tag passes through unchanged.

Top module: `fixed_lat_wb_arb`

## Requirements
- R1: Slot class codes are fixed: 0 means latency 1, 1 means latency 3, 2 means latency 5, and 3 is reserved. A slot with code 3 is never granted and causes no writeback.
- R2: A latency-1 micro-op is placed on the lowest-numbered lane (lane 0, then lane 1, then lane 2) whose writeback slot in the next cycle is free and which has not already been taken this cycle.
- R3: Latency-3 micro-ops are placed only on lane 1 (port 1). Latency-5 micro-ops are placed only on lane 0 (port 0).
- R4: A micro-op is granted only if its lane has no result due at dispatch cycle plus latency, so a lane never has two results due in one cycle.
- R5: Each lane accepts at most one micro-op per cycle.
- R6: Slots are served in index order, so a lower slot index wins any lane both slots could use.
- R7: `grant_o` is raised only for a valid slot. A valid slot that is not granted may be presented again in the next cycle and is granted once a legal lane is free.
- R8: When slot s is granted in cycle t with latency L, `wb_valid_o` of its lane is high in cycle t+L and `wb_tag_o` of that lane carries that slot's tag. The lane's writeback valid is high in no other cycle unless another dispatch caused it.
- R9: While `rst_ni` is low, and after it is released, all reservations are empty and no writeback is valid. No grant is given while reset is held.
- R10: `grant_port_o` for each slot gives the lane index: 0 for port 0, 1 for port 1, 2 for port 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | NUM_SLOTS | Candidate present in each slot (slot 0 is the oldest) |
| slot_cls_i | input | 2*NUM_SLOTS | Latency class per slot, 2 bits each |
| slot_tag_i | input | TAG_W*NUM_SLOTS | Tag per slot |
| grant_o | output | NUM_SLOTS | Slot dispatched this cycle |
| grant_port_o | output | 2*NUM_SLOTS | Lane index chosen per slot |
| wb_valid_o | output | 3 | Writeback valid, one bit per lane |
| wb_tag_o | output | 3*TAG_W | Writeback tag, one field per lane |

## Verification
The bench builds the block with its default values: three input slots and 8-bit tags. The reservation depth is fixed at six by the longest latency class. Three slots are enough to oversubscribe the three lanes and to put two latency-5 candidates against the one legal lane in the same cycle. With tags this wide, each writeback is matched to the micro-op that caused it, and misrouted tags show up. Random traffic mixes the latency-1, -3 and -5 classes so that mixed-latency collisions on lanes 0 and 1 occur often. Directed cases cover the reserved class, the lane-1 conflict between a latency-3 and a later latency-1 micro-op, and age ordering.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_LANES = 3;
  localparam int LAT_SHORT = 1;
  localparam int LAT_MID   = 3;
  localparam int LAT_LONG  = 5;
  // index 0 = writeback this cycle, index k = k cycles ahead
  localparam int DEPTH     = LAT_LONG + 1;

  typedef enum logic [1:0] {
    CLS_L1  = 2'd0,
    CLS_L3  = 2'd1,
    CLS_L5  = 2'd2,
    CLS_RSV = 2'd3
  } lat_cls_e;

  function automatic int lat_of(logic [1:0] cls);
    case (cls)
      CLS_L1:  return LAT_SHORT;
      CLS_L3:  return LAT_MID;
      CLS_L5:  return LAT_LONG;
      default: return 0;
    endcase
  endfunction

  // legal lanes per class, bit k = lane k
  function automatic logic [NUM_LANES-1:0] lane_mask(logic [1:0] cls);
    case (cls)
      CLS_L1:  return 3'b111;
      CLS_L3:  return 3'b010;
      CLS_L5:  return 3'b001;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/wb_lane_pipe.sv
module wb_lane_pipe #(
  parameter int DEPTH = 6,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic [TAG_W-1:0] load_tag_i,
  output logic [DEPTH-1:0] busy_o,
  output logic             wb_valid_o,
  output logic [TAG_W-1:0] wb_tag_o
);
  logic [DEPTH-1:0] v_q, v_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];

  always_comb begin
    v_d = {1'b0, v_q[DEPTH-1:1]};
    for (int i = 0; i < DEPTH - 1; i++) tag_d[i] = tag_q[i+1];
    tag_d[DEPTH-1] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (load_i && (int'(load_idx_i) == i)) begin
        v_d[i]   = 1'b1;
        tag_d[i] = load_tag_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else begin
      v_q <= v_d;
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= tag_d[i];
    end
  end

  assign busy_o     = v_q;
  assign wb_valid_o = v_q[0];
  assign wb_tag_o   = tag_q[0];
endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc
  import arb_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int TAG_W     = 8,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic [NUM_SLOTS-1:0]       cand_i,
  input  logic [2*NUM_SLOTS-1:0]     cls_i,
  input  logic [TAG_W*NUM_SLOTS-1:0] tag_i,
  input  logic [NUM_LANES*DEPTH-1:0] busy_i,
  output logic [NUM_SLOTS-1:0]       grant_o,
  output logic [2*NUM_SLOTS-1:0]     gport_o,
  output logic [NUM_LANES-1:0]       lane_load_o,
  output logic [NUM_LANES*IDX_W-1:0] lane_idx_o,
  output logic [NUM_LANES*TAG_W-1:0] lane_tag_o
);
  logic [NUM_LANES-1:0] taken;

  always_comb begin
    taken       = '0;
    grant_o     = '0;
    gport_o     = '0;
    lane_load_o = '0;
    lane_idx_o  = '0;
    lane_tag_o  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      logic [1:0]           cls;
      logic [NUM_LANES-1:0] legal;
      int                   lat;
      int                   sel;
      cls   = cls_i[2*s +: 2];
      lat   = lat_of(cls);
      legal = lane_mask(cls);
      sel   = -1;
      if (cand_i[s]) begin
        for (int p = 0; p < NUM_LANES; p++) begin
          if (sel < 0 && legal[p] && !taken[p] && !busy_i[p*DEPTH + lat])
            sel = p;
        end
      end
      if (sel >= 0) begin
        taken[sel]                     = 1'b1;
        grant_o[s]                     = 1'b1;
        gport_o[2*s +: 2]              = 2'(sel);
        lane_load_o[sel]               = 1'b1;
        lane_idx_o[sel*IDX_W +: IDX_W] = IDX_W'(lat - 1);
        lane_tag_o[sel*TAG_W +: TAG_W] = tag_i[s*TAG_W +: TAG_W];
      end
    end
  end
endmodule

// File: rtl/fixed_lat_wb_arb.sv
module fixed_lat_wb_arb
  import arb_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int TAG_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SLOTS-1:0]       slot_valid_i,
  input  logic [2*NUM_SLOTS-1:0]     slot_cls_i,
  input  logic [TAG_W*NUM_SLOTS-1:0] slot_tag_i,
  output logic [NUM_SLOTS-1:0]       grant_o,
  output logic [2*NUM_SLOTS-1:0]     grant_port_o,
  output logic [NUM_LANES-1:0]       wb_valid_o,
  output logic [NUM_LANES*TAG_W-1:0] wb_tag_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [NUM_SLOTS-1:0]       cand;
  logic [NUM_LANES*DEPTH-1:0] busy;
  logic [NUM_LANES-1:0]       lane_load;
  logic [NUM_LANES*IDX_W-1:0] lane_idx;
  logic [NUM_LANES*TAG_W-1:0] lane_tag;

  // no dispatch while the reservation map is held in reset
  assign cand = slot_valid_i & {NUM_SLOTS{rst_ni}};

  wb_slot_alloc #(.NUM_SLOTS(NUM_SLOTS), .TAG_W(TAG_W)) u_alloc (
    .cand_i      (cand),
    .cls_i       (slot_cls_i),
    .tag_i       (slot_tag_i),
    .busy_i      (busy),
    .grant_o     (grant_o),
    .gport_o     (grant_port_o),
    .lane_load_o (lane_load),
    .lane_idx_o  (lane_idx),
    .lane_tag_o  (lane_tag)
  );

  for (genvar p = 0; p < NUM_LANES; p++) begin : g_lane
    wb_lane_pipe #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pipe (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (lane_load[p]),
      .load_idx_i (lane_idx[p*IDX_W +: IDX_W]),
      .load_tag_i (lane_tag[p*TAG_W +: TAG_W]),
      .busy_o     (busy[p*DEPTH +: DEPTH]),
      .wb_valid_o (wb_valid_o[p]),
      .wb_tag_o   (wb_tag_o[p*TAG_W +: TAG_W])
    );
  end
endmodule

// File: rtl/fixed_lat_wb_arb_chk.sv
module fixed_lat_wb_arb_chk
  import arb_pkg::*;
#(
  parameter int NUM_SLOTS = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_SLOTS-1:0]   slot_valid_i,
  input logic [2*NUM_SLOTS-1:0] slot_cls_i,
  input logic [NUM_SLOTS-1:0]   grant_o,
  input logic [2*NUM_SLOTS-1:0] grant_port_o,
  input logic [NUM_LANES-1:0]   wb_valid_o
);
  logic [NUM_SLOTS-1:0] hit [NUM_LANES];
  logic [NUM_LANES-1:0] g1;
  logic                 g3, g5;

  always_comb begin
    g1 = '0;
    g3 = 1'b0;
    g5 = 1'b0;
    for (int p = 0; p < NUM_LANES; p++) hit[p] = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (grant_o[s]) begin
        for (int p = 0; p < NUM_LANES; p++)
          if (int'(grant_port_o[2*s +: 2]) == p) hit[p][s] = 1'b1;
        if (slot_cls_i[2*s +: 2] == CLS_L1)
          for (int p = 0; p < NUM_LANES; p++)
            if (int'(grant_port_o[2*s +: 2]) == p) g1[p] = 1'b1;
        if (slot_cls_i[2*s +: 2] == CLS_L3) g3 = 1'b1;
        if (slot_cls_i[2*s +: 2] == CLS_L5) g5 = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    p_grant_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[s] |-> slot_valid_i[s]);
    p_rsv_blocked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_cls_i[2*s +: 2] == CLS_RSV) |-> !grant_o[s]);
    p_mid_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[s] && slot_cls_i[2*s +: 2] == CLS_L3) |-> grant_port_o[2*s +: 2] == 2'd1);
    p_long_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[s] && slot_cls_i[2*s +: 2] == CLS_L5) |-> grant_port_o[2*s +: 2] == 2'd0);
  end

  for (genvar p = 0; p < NUM_LANES; p++) begin : g_lanechk
    p_one_per_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hit[p]) <= 1);
    p_short_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      g1[p] |=> wb_valid_o[p]);
  end

  p_mid_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g3 |-> ##3 wb_valid_o[1]);
  p_long_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g5 |-> ##5 wb_valid_o[0]);
  p_no_clash_l0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g1[0] |-> !$past(g5, 4));
  p_no_clash_l1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g1[1] |-> !$past(g3, 2));
  p_quiet_reset_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (grant_o == '0));
endmodule

bind fixed_lat_wb_arb fixed_lat_wb_arb_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_valid_i (slot_valid_i),
  .slot_cls_i   (slot_cls_i),
  .grant_o      (grant_o),
  .grant_port_o (grant_port_o),
  .wb_valid_o   (wb_valid_o)
);

// File: tb/tb_fixed_lat_wb_arb.sv
module tb_fixed_lat_wb_arb;
  import arb_pkg::*;
  localparam int NS = 3;
  localparam int TW = 8;
  localparam int RING = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NS-1:0]    slot_valid;
  logic [2*NS-1:0]  slot_cls;
  logic [TW*NS-1:0] slot_tag;
  logic [NS-1:0]    grant;
  logic [2*NS-1:0]  grant_port;
  logic [2:0]       wb_valid;
  logic [3*TW-1:0]  wb_tag;

  always #10 clk = ~clk;

  fixed_lat_wb_arb #(.NUM_SLOTS(NS), .TAG_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .slot_valid_i(slot_valid), .slot_cls_i(slot_cls),
    .slot_tag_i(slot_tag), .grant_o(grant), .grant_port_o(grant_port),
    .wb_valid_o(wb_valid), .wb_tag_o(wb_tag));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit rand_fill = 0;
  bit done = 0;

  bit         pv [NS];
  logic [1:0] pc [NS];
  logic [TW-1:0] pt [NS];
  bit         exp_v [3][RING];
  logic [TW-1:0] exp_t [3][RING];
  bit         mg [NS];
  int         mp [NS];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic load(int s, logic [1:0] c, logic [TW-1:0] t);
    pv[s] = 1; pc[s] = c; pt[s] = t;
  endtask

  // drive, evaluate reference model, compare
  task automatic eval();
    bit taken [3];
    @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      slot_valid[s]        = pv[s];
      slot_cls[2*s +: 2]   = pc[s];
      slot_tag[s*TW +: TW] = pt[s];
    end
    #1;
    for (int p = 0; p < 3; p++) taken[p] = 0;
    for (int s = 0; s < NS; s++) begin
      int lat;
      lat = lat_of(pc[s]);
      mg[s] = 0; mp[s] = -1;
      if (pv[s]) begin
        for (int p = 0; p < 3; p++) begin
          bit legal;
          legal = (pc[s] == CLS_L1) || (pc[s] == CLS_L3 && p == 1) || (pc[s] == CLS_L5 && p == 0);
          if (mp[s] < 0 && legal && !taken[p] && !exp_v[p][(cyc + lat) % RING]) mp[s] = p;
        end
      end
      if (mp[s] >= 0) begin
        mg[s] = 1; taken[mp[s]] = 1;
      end
    end
    for (int s = 0; s < NS; s++) begin
      string rq;
      rq = (pc[s] == CLS_RSV) ? "R1" : (pc[s] == CLS_L1) ? "R2/R4/R6" : "R3/R4/R6";
      chk(grant[s] == mg[s], rq, $sformatf("grant slot%0d", s), int'(grant[s]), int'(mg[s]));
      if (mg[s] && grant[s])
        chk(int'(grant_port[2*s +: 2]) == mp[s], "R10", $sformatf("port slot%0d", s),
            int'(grant_port[2*s +: 2]), mp[s]);
    end
    for (int p = 0; p < 3; p++) begin
      chk(wb_valid[p] == exp_v[p][cyc % RING], "R8", $sformatf("wb_valid lane%0d", p),
          int'(wb_valid[p]), int'(exp_v[p][cyc % RING]));
      if (exp_v[p][cyc % RING] && wb_valid[p])
        chk(wb_tag[p*TW +: TW] == exp_t[p][cyc % RING], "R8", $sformatf("wb_tag lane%0d", p),
            int'(wb_tag[p*TW +: TW]), int'(exp_t[p][cyc % RING]));
      exp_v[p][cyc % RING] = 0;
    end
    for (int s = 0; s < NS; s++) begin
      if (mg[s]) begin
        int at;
        at = (cyc + lat_of(pc[s])) % RING;
        exp_v[mp[s]][at] = 1;
        exp_t[mp[s]][at] = pt[s];
        pv[s] = 0;  // R7: ungranted slots stay pending
      end
    end
  endtask

  task automatic adv();
    @(posedge clk);
    cyc++;
    if (rand_fill)
      for (int s = 0; s < NS; s++)
        if (!pv[s] && ($urandom % 3 != 0)) load(s, 2'($urandom % 3), TW'($urandom));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin eval(); adv(); end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NS; s++) begin pv[s] = 0; pc[s] = 0; pt[s] = 0; end
    for (int p = 0; p < 3; p++) for (int i = 0; i < RING; i++) begin exp_v[p][i] = 0; exp_t[p][i] = 0; end
    slot_valid = '0; slot_cls = '0; slot_tag = '0;
    repeat (3) @(posedge clk);
    chk(wb_valid == 3'b000, "R9", "wb_valid in reset", int'(wb_valid), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); cyc = 0;

    // R9: empty after reset, first short op lands on lane 0
    load(0, CLS_L1, 8'h11);
    eval();
    chk(grant[0] && grant_port[1:0] == 2'd0, "R9", "first short op lane", int'(grant_port[1:0]), 0);
    adv();
    idle(2);

    // R4: mid op reserves lane1 at t+3; short ops at t+2 must avoid lane1
    load(0, CLS_L3, 8'h21);
    eval(); adv();
    idle(1);
    load(0, CLS_L1, 8'h31); load(1, CLS_L1, 8'h32); load(2, CLS_L1, 8'h33);
    eval();
    chk(grant == 3'b011, "R4/R5", "grant mask on lane1 clash", int'(grant), 3);
    chk(grant_port[3:2] == 2'd2, "R4", "slot1 skips reserved lane1", int'(grant_port[3:2]), 2);
    adv();
    eval();
    chk(grant[2] == 1'b1, "R7", "held slot granted next cycle", int'(grant[2]), 1);
    adv();
    idle(6);

    // R6: two long ops compete for lane0, older wins
    load(0, CLS_L5, 8'h41); load(1, CLS_L5, 8'h42);
    eval();
    chk(grant == 3'b001, "R6/R5", "older long op wins", int'(grant), 1);
    adv();
    eval();
    chk(grant[1] == 1'b1, "R7", "younger long op retried", int'(grant[1]), 1);
    adv();
    // short op whose next slot collides with a long result moves to lane1
    idle(3);
    load(0, CLS_L1, 8'h51);
    eval();
    chk(grant_port[1:0] == 2'd1, "R4/R2", "short op avoids lane0 long result", int'(grant_port[1:0]), 1);
    adv();
    idle(6);

    // R1: reserved class never granted
    load(2, CLS_RSV, 8'h61);
    for (int i = 0; i < 3; i++) begin
      eval();
      chk(grant[2] == 1'b0, "R1", "reserved class grant", int'(grant[2]), 0);
      adv();
    end
    pv[2] = 0;
    idle(6);

    rand_fill = 1;
    idle(4000);
    rand_fill = 0;
    idle(12);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule